// File: doc/BRIEF.md
# Two-Digit Multiplexed Seven-Segment Display Controller

This block drives a pair of seven-segment digits that share one segment bus. It lights one digit at a time and alternates between them every 8 ms, so the two digits switch at 125 Hz. Each digit holds a 5-bit character code taken from a 22-glyph set. The code is decoded to a segment pattern while that digit is enabled. A host loads both codes together through two byte-wide write ports and a single strobe. The upper three bits of each byte carry no meaning. After reset the display reads "00".

When the serial clock pin and the serial data pin are both strapped low as reset is released, the block enters a self-test mode. In that mode it ignores host writes and shows the same character on both digits. The character steps through the whole glyph set, one glyph every 250 ms. Only a new reset leaves self-test. Timing is derived from the `CLK_HZ` parameter. The asynchronous reset passes through a two-stage synchronizer before it reaches the logic.

Top module: `disp2_ctrl`

## Requirements
- R1: After reset, unless self-test was entered, both digits show character code 0 until the first write.
- R2: `seg_o` is active high, with bit 0 = segment a through bit 6 = segment g. Codes 0..21 decode to these patterns: 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F 10:77 11:7C 12:39 13:5E 14:79 15:71 16:76 17:38 18:5C 19:73 20:3E 21:40 (hex).
- R3: Exactly one bit of `dig_en_o` is high at any time. Bit 0 selects digit 0, which is lit first after reset. Each enable stays high for DIG_CYC = CLK_HZ*8/1000 clocks, and then the other digit takes over.
- R4: During the first clock of every enable window, `seg_o` is all zeros.
- R5: Codes 22..31 decode to all segments off. Bits 7..5 of each write byte are ignored.
- R6: A cycle with `wr_stb` high loads `wr_code0` into digit 0 and `wr_code1` into digit 1. The new patterns appear on the clock after the strobe edge.
- R7: The pins `sck_in` and `sdi_in` are sampled once, at the third rising clock edge after `rst_n` rises. Self-test is entered only if both pins are low at that edge.
- R8: In self-test, both digits show a counter value. The counter starts at 0, advances every STEP_CYC = CLK_HZ*250/1000 clocks counted from the first active edge, and wraps from 21 to 0.
- R9: In self-test, `wr_stb` has no effect. The mode persists until `rst_n` is asserted again.
- R10: While `rst_n` is low, `dig_en_o` is 01 and `seg_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Load strobe for both character codes |
| wr_code0 | input | 8 | Code for digit 0 (bits 4..0 used) |
| wr_code1 | input | 8 | Code for digit 1 (bits 4..0 used) |
| sck_in | input | 1 | Serial clock pin level, for self-test strap |
| sdi_in | input | 1 | Serial data pin level, for self-test strap |
| seg_o | output | 7 | Segment lines a..g, active high |
| dig_en_o | output | 2 | Digit enables, one-hot |

## Verification
The synchronizer delays the first active edge to the third rising edge after release. Every result is due at a fixed count of logic edges from that point:
- A write shows one edge after its strobe.
- A digit switch happens every DIG_CYC edges.
- A self-test step happens every STEP_CYC edges.

The outputs are decoded directly from registers. The bench therefore keeps its own count of logic edges and its own shadow of the loaded codes and the strap. It compares `seg_o` and `dig_en_o` on every falling edge against values computed from that count. This means each result is checked in exactly the cycle it is due and in every cycle after that.

// File: rtl/disp2_pkg.sv
package disp2_pkg;
  localparam int unsigned NCHAR  = 22;
  localparam int unsigned CHAR_W = 5;
  localparam int unsigned SEG_W  = 7;

  typedef logic [CHAR_W-1:0] char_t;
  typedef logic [SEG_W-1:0]  seg_t;

  // Segment order: bit 0 = a ... bit 6 = g, active high.
  function automatic seg_t glyph(input char_t c);
    seg_t s;
    case (c)
      5'd0:  s = 7'h3F;
      5'd1:  s = 7'h06;
      5'd2:  s = 7'h5B;
      5'd3:  s = 7'h4F;
      5'd4:  s = 7'h66;
      5'd5:  s = 7'h6D;
      5'd6:  s = 7'h7D;
      5'd7:  s = 7'h07;
      5'd8:  s = 7'h7F;
      5'd9:  s = 7'h6F;
      5'd10: s = 7'h77;
      5'd11: s = 7'h7C;
      5'd12: s = 7'h39;
      5'd13: s = 7'h5E;
      5'd14: s = 7'h79;
      5'd15: s = 7'h71;
      5'd16: s = 7'h76;
      5'd17: s = 7'h38;
      5'd18: s = 7'h5C;
      5'd19: s = 7'h73;
      5'd20: s = 7'h3E;
      5'd21: s = 7'h40;
      default: s = '0; // R5: unused codes stay dark
    endcase
    return s;
  endfunction
endpackage

// File: rtl/disp2_scan.sv
module disp2_scan #(
  parameter int unsigned DIG_CYC = 8000
) (
  input  logic clk,
  input  logic rst_n,
  output logic sel,
  output logic blank
);
  localparam int unsigned CNT_W = (DIG_CYC > 2) ? $clog2(DIG_CYC) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sel_q, sel_d;
  logic             wrap;

  always_comb begin
    wrap  = (cnt_q == CNT_W'(DIG_CYC - 1));
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    sel_d = wrap ? ~sel_q : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= sel_d;
    end
  end

  assign sel   = sel_q;
  assign blank = (cnt_q == '0);
endmodule

// File: rtl/disp2_selftest.sv
module disp2_selftest
  import disp2_pkg::*;
#(
  parameter int unsigned STEP_CYC = 250000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sck_in,
  input  logic  sdi_in,
  output logic  test_mode,
  output char_t test_val
);
  localparam int unsigned TC_W = (STEP_CYC > 2) ? $clog2(STEP_CYC) : 1;

  logic            armed_q, armed_d;
  logic            mode_q, mode_d;
  logic [TC_W-1:0] tcnt_q, tcnt_d;
  char_t           val_q, val_d;
  logic            tick;

  always_comb begin
    armed_d = 1'b1;
    mode_d  = armed_q ? mode_q : (~sck_in & ~sdi_in);
    tick    = (tcnt_q == TC_W'(STEP_CYC - 1));
    tcnt_d  = tick ? '0 : tcnt_q + 1'b1;
    val_d   = val_q;
    if (mode_q && tick)
      val_d = (val_q == char_t'(NCHAR - 1)) ? '0 : val_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      mode_q  <= 1'b0;
      tcnt_q  <= '0;
      val_q   <= '0;
    end else begin
      armed_q <= armed_d;
      mode_q  <= mode_d;
      tcnt_q  <= tcnt_d;
      val_q   <= val_d;
    end
  end

  assign test_mode = mode_q;
  assign test_val  = val_q;
endmodule

// File: rtl/disp2_ctrl.sv
module disp2_ctrl
  import disp2_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 1000000,
  parameter int unsigned DIGIT_MS = 8,
  parameter int unsigned STEP_MS  = 250,
  parameter int unsigned CODE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [CODE_W-1:0] wr_code0,
  input  logic [CODE_W-1:0] wr_code1,
  input  logic              sck_in,
  input  logic              sdi_in,
  output logic [SEG_W-1:0]  seg_o,
  output logic [1:0]        dig_en_o
);
  localparam int unsigned DIG_CYC  = CLK_HZ * DIGIT_MS / 1000;
  localparam int unsigned STEP_CYC = CLK_HZ * STEP_MS / 1000;
  localparam int unsigned NDIG     = 2;

  // Reset synchronizer: assert asynchronously, release on the clock.
  logic rs1_q, rs2_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_sync_n = rs2_q;

  logic  sel, blank, test_mode;
  char_t test_val;

  disp2_scan #(.DIG_CYC(DIG_CYC)) u_scan (
    .clk(clk), .rst_n(rst_sync_n), .sel(sel), .blank(blank)
  );

  disp2_selftest #(.STEP_CYC(STEP_CYC)) u_test (
    .clk(clk), .rst_n(rst_sync_n), .sck_in(sck_in), .sdi_in(sdi_in),
    .test_mode(test_mode), .test_val(test_val)
  );

  // Per-digit code registers, upper byte bits dropped.
  char_t [NDIG-1:0] code_q;
  char_t [NDIG-1:0] wr_bus;
  logic             wr_en;

  assign wr_bus[0] = wr_code0[CHAR_W-1:0];
  assign wr_bus[1] = wr_code1[CHAR_W-1:0];
  assign wr_en     = wr_stb & ~test_mode;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    char_t code_d;
    always_comb code_d = wr_en ? wr_bus[g] : code_q[g];
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) code_q[g] <= '0;
      else             code_q[g] <= code_d;
    end
  end

  char_t shown;
  always_comb begin
    shown    = test_mode ? test_val : code_q[sel];
    seg_o    = blank ? '0 : glyph(shown);
    dig_en_o = sel ? 2'b10 : 2'b01;
  end
endmodule

// File: rtl/disp2_ctrl_chk.sv
module disp2_ctrl_chk #(
  parameter int unsigned DIG_CYC = 8000
) (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] seg,
  input logic [1:0] dig_en,
  input logic       test_mode,
  input logic [4:0] tval,
  input logic       wr_stb,
  input logic [9:0] codes
);
  localparam int unsigned RUN_W = $clog2(DIG_CYC + 1);

  logic [1:0]       prev_en;
  logic [RUN_W-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_en <= 2'b01;
      run     <= '0;
    end else begin
      prev_en <= dig_en;
      if (dig_en != prev_en)           run <= RUN_W'(1);
      else if (run != RUN_W'(DIG_CYC)) run <= run + 1'b1;
    end
  end

  p_one_digit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dig_en) == 1);
  p_dwell_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_en != prev_en) |-> (run == RUN_W'(DIG_CYC)));
  p_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_en != prev_en) |-> (seg == '0));
  p_val_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tval <= 5'd21);
  p_mode_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> test_mode);
  p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && wr_stb) |=> $stable(codes));
endmodule

bind disp2_ctrl disp2_ctrl_chk #(.DIG_CYC(DIG_CYC)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .seg(seg_o), .dig_en(dig_en_o),
  .test_mode(test_mode), .tval(test_val), .wr_stb(wr_stb), .codes(code_q)
);

// File: tb/disp2_ctrl_bench.sv
`timescale 1ns/1ps
module disp2_ctrl_bench;
  localparam int CLK_HZ = 1000;
  localparam int DIG    = CLK_HZ * 8 / 1000;
  localparam int STEP   = CLK_HZ * 250 / 1000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_stb;
  logic [7:0] wr_code0, wr_code1;
  logic       sck_in, sdi_in;
  logic [6:0] seg_o;
  logic [1:0] dig_en_o;

  disp2_ctrl #(.CLK_HZ(CLK_HZ)) u_disp2_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_code0(wr_code0),
    .wr_code1(wr_code1), .sck_in(sck_in), .sdi_in(sdi_in),
    .seg_o(seg_o), .dig_en_o(dig_en_o)
  );

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  logic [6:0] tbl [22] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D,
                            7'h07, 7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E,
                            7'h79, 7'h71, 7'h76, 7'h38, 7'h5C, 7'h73, 7'h3E,
                            7'h40};

  // Shadow model: edges since release, logic edges, codes, strap.
  int e, nl;
  logic [4:0] m0, m1;
  bit tm;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e = 0; nl = 0; m0 = '0; m1 = '0; tm = 1'b0;
    end else begin
      if (e >= 2) begin
        if (wr_stb && !tm) begin
          m0 = wr_code0[4:0];
          m1 = wr_code1[4:0];
        end
        if (nl == 0) tm = !sck_in && !sdi_in;
        nl = nl + 1;
      end
      e = e + 1;
    end
  end

  function automatic logic [6:0] pat(input logic [4:0] c);
    return (c < 22) ? tbl[c] : 7'h00;
  endfunction

  task automatic check();
    logic [1:0] en_x;
    logic [6:0] seg_x;
    logic [4:0] ch;
    int cnt, sel;
    cnt = nl % DIG;
    sel = (nl / DIG) % 2;
    ch  = tm ? 5'((nl / STEP) % 22) : (sel ? m1 : m0);
    en_x  = sel ? 2'b10 : 2'b01;
    seg_x = (cnt == 0) ? 7'h00 : pat(ch);
    nchk++;
    if (dig_en_o !== en_x) begin
      nfail++;
      $display("FAIL R3 dig_en actual=%b expected=%b (nl=%0d)", dig_en_o, en_x, nl);
    end
    nchk++;
    if (seg_o !== seg_x) begin
      nfail++;
      if (cnt == 0)
        $display("FAIL R4 seg actual=%h expected=%h (nl=%0d)", seg_o, seg_x, nl);
      else if (tm)
        $display("FAIL R8 seg actual=%h expected=%h (nl=%0d)", seg_o, seg_x, nl);
      else
        $display("FAIL R2/R5/R6 seg actual=%h expected=%h (nl=%0d)", seg_o, seg_x, nl);
    end
  endtask

  task automatic run(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      check();
    end
  endtask

  task automatic do_reset(input logic sck, input logic sdi);
    @(negedge clk);
    rst_n = 1'b0;
    sck_in = sck;
    sdi_in = sdi;
    run(3); // R10: reset state checked while rst_n is low
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; wr_stb = 1'b0; wr_code0 = '0; wr_code1 = '0;
    sck_in = 1'b1; sdi_in = 1'b1;

    // R10, R1, R3, R4: reset with normal pins, default "00"
    do_reset(1'b1, 1'b1);
    run(5 * DIG);

    // R2, R5, R6: sweep all 32 codes with junk in bits 7..5
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      wr_stb = 1'b1;
      wr_code0 = {3'(c), 5'(c)};
      wr_code1 = {~3'(c), 5'(31 - c)};
      check();
      @(negedge clk);
      wr_stb = 1'b0;
      wr_code0 = 8'hFF;
      wr_code1 = 8'hFF;
      check();
      run(2 * DIG + (c % 5));
    end

    // R7: only one pin low -> normal mode, "00"
    do_reset(1'b0, 1'b1);
    run(3 * DIG);
    do_reset(1'b1, 1'b0);
    run(3 * DIG);

    // R7, R8, R9: both pins low -> self-test; writes must be ignored
    do_reset(1'b0, 1'b0);
    run(10);
    sck_in = 1'b1; sdi_in = 1'b1;
    run(STEP);
    @(negedge clk);
    wr_stb = 1'b1; wr_code0 = 8'h08; wr_code1 = 8'h08;
    check();
    @(negedge clk);
    wr_stb = 1'b0;
    check();
    run(22 * STEP + 40); // full wrap 21 -> 0

    // R9: new reset with normal pins leaves self-test, back to "00"
    do_reset(1'b1, 1'b1);
    run(3 * DIG);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule